// File: doc/BRIEF.md
# Programmable Raster Sync Generator

This block generates the horizontal sync, vertical sync and data-enable waveforms for an RGB panel driven by a continuous dot clock. It also produces a pixel-request strobe for the pixel formatter and a one-cycle frame-start pulse for the frame-base double buffer. All timing comes from configuration inputs. A line is described by its total period in dot clocks, the width of the sync pulse, a wait count measured from the start of sync to the first active pixel, and the number of active pixels. A frame is described the same way, in lines.

Each of the three panel outputs has its own polarity input. A separate gate, `sync_on`, holds all outputs at their inactive levels and keeps both counters at zero while it is low. Software raises this gate before starting the pixel engine and drops it after the engine stops. The data-enable pin can be disabled on its own for panels that take their timing from sync alone.

The pixel-request strobe and the frame-start pulse are plain strobes with no ready input. A panel cannot be stalled, so the formatter must accept a pixel on every cycle in which the strobe is high. Configuration inputs are expected to change only while `sync_on` is low.

Top module: `vtg_top`

## Requirements
- R1: While reset is asserted, and while `sync_on` is low, each sync output sits at its inactive level: 0 when its polarity input is 1 and 1 when it is 0. `pix_req_o` and `frame_start_o` are 0.
- R2: The horizontal count runs from 0 to `line_period`-1 and then returns to 0. A period of 0 behaves as 1. Horizontal sync is active for counts below `hs_width`.
- R3: The line count advances when the horizontal count wraps and returns to 0 after line `frame_lines`-1. Vertical sync is active during all counts of lines below `vs_width`.
- R4: The horizontal active window covers counts `h_wait` through `h_wait`+`h_valid`-1. These counts are taken from the start of sync, and `h_valid`=0 gives no active pixels.
- R5: The vertical active window covers lines `v_wait` through `v_wait`+`v_valid`-1.
- R6: `pix_req_o` is high exactly when both windows are active. Data-enable is active under the same condition only when `de_present` is 1; otherwise it stays inactive.
- R7: Each of `hsync_o`, `vsync_o` and `de_o` is active-high when its polarity input is 1 and active-low when it is 0.
- R8: `frame_start_o` is a one-cycle pulse issued for horizontal count 0 of line 0, which means once per frame.
- R9: Every output reflects the counter state one clock after the edge that samples it. The first clock edge that samples `sync_on` high uses state (0,0). After the edge that samples `sync_on` low, all outputs are inactive and the counters restart from (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_on | input | 1 | Sync gate; low holds outputs inactive and counters at zero |
| hs_active_high | input | 1 | Horizontal sync polarity (1 = active high) |
| vs_active_high | input | 1 | Vertical sync polarity (1 = active high) |
| de_active_high | input | 1 | Data-enable polarity (1 = active high) |
| de_present | input | 1 | Drive data-enable to the panel |
| line_period | input | 18 | Dot clocks per line |
| hs_width | input | 18 | Horizontal sync width in dot clocks |
| h_wait | input | 12 | Dot clocks from sync start to first active pixel |
| h_valid | input | 18 | Active pixels per line |
| frame_lines | input | 16 | Lines per frame |
| vs_width | input | 16 | Vertical sync width in lines |
| v_wait | input | 16 | Lines from vertical sync start to first active line |
| v_valid | input | 16 | Active lines per frame |
| hsync_o | output | 1 | Horizontal sync to panel |
| vsync_o | output | 1 | Vertical sync to panel |
| de_o | output | 1 | Data enable to panel |
| pix_req_o | output | 1 | Pixel request strobe to formatter |
| frame_start_o | output | 1 | One-cycle pulse at the start of each frame |

## Verification
Every output is due exactly one clock after the edge that samples the counter state it describes. The first state, (0,0), is sampled on the first edge that sees `sync_on` high, and the inactive levels appear one clock after the edge that sees it low. The bench's driver process evaluates the requirement equations for the state at each rising edge and queues the expected flags. The monitor removes one entry at each falling edge, after the register has updated, and applies the current polarity inputs when it compares. Inputs change a quarter period after a falling edge so that no edge races the stimulus. Per-run totals of frame-start pulses and pixel requests are compared against frame counts worked out by hand.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int NUM_SYNC = 3;  // hsync, vsync, data-enable

  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
    logic req;
    logic fs;
  } vtg_flags_t;

  function automatic logic drive_level(input logic active, input logic act_high);
    return act_high ? active : ~active;
  endfunction
endpackage

// File: rtl/vtg_axis.sv
module vtg_axis #(
  parameter int CNT_W  = 18,
  parameter int WAIT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              step,
  input  logic [CNT_W-1:0]  period,
  input  logic [CNT_W-1:0]  pulse_w,
  input  logic [WAIT_W-1:0] wait_cnt,
  input  logic [CNT_W-1:0]  valid_cnt,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              last_o,
  output logic              in_pulse_o,
  output logic              in_win_o,
  output logic              at_zero_o
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] cnt_ext, win_lo, win_hi;

  assign cnt_ext = {1'b0, cnt_q};
  assign win_lo  = EXT_W'(wait_cnt);
  assign win_hi  = win_lo + {1'b0, valid_cnt};

  assign last_o     = (cnt_ext + EXT_W'(1)) >= {1'b0, period};
  assign in_pulse_o = cnt_q < pulse_w;
  assign in_win_o   = (cnt_ext >= win_lo) && (cnt_ext < win_hi);
  assign at_zero_o  = (cnt_q == '0);
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (step)    cnt_q <= last_o ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/vtg_outstage.sv
module vtg_outstage
  import vtg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  vtg_flags_t          flags_d,
  input  logic [NUM_SYNC-1:0] pol_high,
  output logic [NUM_SYNC-1:0] sync_o,
  output logic                req_o,
  output logic                fs_o
);
  vtg_flags_t          flags_q;
  logic [NUM_SYNC-1:0] act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flags_q <= '0;
    else if (!run) flags_q <= '0;
    else           flags_q <= flags_d;
  end

  assign act = {flags_q.de, flags_q.vs, flags_q.hs};

  for (genvar i = 0; i < NUM_SYNC; i++) begin : g_pol
    assign sync_o[i] = drive_level(act[i], pol_high[i]);
  end

  assign req_o = flags_q.req;
  assign fs_o  = flags_q.fs;
endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter int HP_W    = 18,
  parameter int HWAIT_W = 12,
  parameter int VP_W    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_on,
  input  logic               hs_active_high,
  input  logic               vs_active_high,
  input  logic               de_active_high,
  input  logic               de_present,
  input  logic [HP_W-1:0]    line_period,
  input  logic [HP_W-1:0]    hs_width,
  input  logic [HWAIT_W-1:0] h_wait,
  input  logic [HP_W-1:0]    h_valid,
  input  logic [VP_W-1:0]    frame_lines,
  input  logic [VP_W-1:0]    vs_width,
  input  logic [VP_W-1:0]    v_wait,
  input  logic [VP_W-1:0]    v_valid,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic               pix_req_o,
  output logic               frame_start_o
);
  logic [HP_W-1:0]     h_cnt;
  logic [VP_W-1:0]     v_cnt;
  logic                h_last, h_pulse, h_win, h_zero;
  logic                v_last, v_pulse, v_win, v_zero;
  vtg_flags_t          flags;
  logic [NUM_SYNC-1:0] sync_lv;

  vtg_axis #(.CNT_W(HP_W), .WAIT_W(HWAIT_W)) i_h_axis (
    .clk(clk), .rst_n(rst_n), .run(sync_on), .step(1'b1),
    .period(line_period), .pulse_w(hs_width), .wait_cnt(h_wait),
    .valid_cnt(h_valid), .cnt_o(h_cnt), .last_o(h_last),
    .in_pulse_o(h_pulse), .in_win_o(h_win), .at_zero_o(h_zero)
  );

  vtg_axis #(.CNT_W(VP_W), .WAIT_W(VP_W)) i_v_axis (
    .clk(clk), .rst_n(rst_n), .run(sync_on), .step(h_last),
    .period(frame_lines), .pulse_w(vs_width), .wait_cnt(v_wait),
    .valid_cnt(v_valid), .cnt_o(v_cnt), .last_o(v_last),
    .in_pulse_o(v_pulse), .in_win_o(v_win), .at_zero_o(v_zero)
  );

  always_comb begin
    flags.hs  = h_pulse;
    flags.vs  = v_pulse;
    flags.req = h_win && v_win;
    flags.de  = h_win && v_win && de_present;
    flags.fs  = h_zero && v_zero;
  end

  vtg_outstage i_out (
    .clk(clk), .rst_n(rst_n), .run(sync_on), .flags_d(flags),
    .pol_high({de_active_high, vs_active_high, hs_active_high}),
    .sync_o(sync_lv), .req_o(pix_req_o), .fs_o(frame_start_o)
  );

  assign hsync_o = sync_lv[0];
  assign vsync_o = sync_lv[1];
  assign de_o    = sync_lv[2];
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
  parameter int HP_W = 18,
  parameter int VP_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sync_on,
  input logic            de_active_high,
  input logic [HP_W-1:0] line_period,
  input logic [HP_W-1:0] h_cnt,
  input logic            h_last,
  input logic [VP_W-1:0] v_cnt,
  input logic            vsync_o,
  input logic            de_o,
  input logic            pix_req_o,
  input logic            frame_start_o
);
  localparam logic [HP_W-1:0] H_ONE = {{(HP_W-1){1'b0}}, 1'b1};

  AST_HCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_on && !h_last) |=> (h_cnt == $past(h_cnt) + H_ONE)); // R2

  AST_VSYNC_LINE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_on && $past(sync_on) && h_cnt != H_ONE) |-> $stable(vsync_o)); // R3

  AST_DE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (de_o == de_active_high) |-> pix_req_o); // R6

  AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_o && line_period > H_ONE) |=> !frame_start_o); // R8

  AST_GATE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_on |=> (!pix_req_o && !frame_start_o && h_cnt == '0 && v_cnt == '0)); // R9
endmodule

bind vtg_top vtg_checker #(.HP_W(HP_W), .VP_W(VP_W)) i_vtg_checker (
  .clk(clk), .rst_n(rst_n), .sync_on(sync_on), .de_active_high(de_active_high),
  .line_period(line_period), .h_cnt(h_cnt), .h_last(h_last), .v_cnt(v_cnt),
  .vsync_o(vsync_o), .de_o(de_o), .pix_req_o(pix_req_o),
  .frame_start_o(frame_start_o)
);

// File: tb/test_vtg_top.sv
module test_vtg_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic hs; logic vs; logic de; logic req; logic fs;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_on = 1'b0;
  logic        hs_pol = 1'b1, vs_pol = 1'b0, de_pol = 1'b0, de_pres = 1'b1;
  logic [17:0] lp = 18'd20, hsw = 18'd3, hv = 18'd8;
  logic [11:0] hw = 12'd6;
  logic [15:0] fl = 16'd10, vsw = 16'd2, vw = 16'd3, vv = 16'd4;
  logic        hsync_o, vsync_o, de_o, pix_req_o, frame_start_o;

  int tests = 0, fails = 0;
  int fs_cnt = 0, req_cnt = 0;
  int mh = 0, mv = 0;
  bit done = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vtg_top i_vtg_top (
    .clk(clk), .rst_n(rst_n), .sync_on(sync_on),
    .hs_active_high(hs_pol), .vs_active_high(vs_pol), .de_active_high(de_pol),
    .de_present(de_pres), .line_period(lp), .hs_width(hsw), .h_wait(hw),
    .h_valid(hv), .frame_lines(fl), .vs_width(vsw), .v_wait(vw), .v_valid(vv),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .pix_req_o(pix_req_o), .frame_start_o(frame_start_o)
  );

  // Driver: expected flags for the state sampled at this edge
  always @(posedge clk) begin
    if (rst_n) begin
      exp_t e;
      bit hwin, vwin;
      e = '0;
      if (sync_on) begin
        e.hs  = mh < int'(hsw);                                  // R2
        e.vs  = mv < int'(vsw);                                  // R3
        hwin  = (mh >= int'(hw)) && (mh < int'(hw) + int'(hv));  // R4
        vwin  = (mv >= int'(vw)) && (mv < int'(vw) + int'(vv));  // R5
        e.req = hwin && vwin;
        e.de  = hwin && vwin && de_pres;                         // R6
        e.fs  = (mh == 0) && (mv == 0);                          // R8
        if (mh + 1 >= int'(lp)) begin
          mh = 0;
          if (mv + 1 >= int'(fl)) mv = 0; else mv = mv + 1;
        end else mh = mh + 1;
      end else begin
        mh = 0; mv = 0;                                          // R9
      end
      q.push_back(e);
    end
  end

  task automatic cmp(input string tag, input logic act, input logic exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // Monitor: outputs are registered, so compare after the edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      tests++;
      cmp("R2/R7 hsync", hsync_o, hs_pol ? e.hs : !e.hs);
      cmp("R3/R7 vsync", vsync_o, vs_pol ? e.vs : !e.vs);
      cmp("R6/R7 de", de_o, de_pol ? e.de : !e.de);
      cmp("R5 pix_req", pix_req_o, e.req);
      cmp("R8 frame_start", frame_start_o, e.fs);
      if (frame_start_o) fs_cnt++;
      if (pix_req_o) req_cnt++;
    end
  end

  task automatic check_int(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_cfg(
    input int l_p, input int h_s, input int h_w, input int h_v,
    input int f_l, input int v_s, input int v_w, input int v_v,
    input logic ph, input logic pv, input logic pd, input logic pres,
    input int cycles, input int exp_fs, input int exp_req);
    int fs0, rq0;
    @(negedge clk); #(CLK_PERIOD/4);
    lp = 18'(l_p); hsw = 18'(h_s); hw = 12'(h_w); hv = 18'(h_v);
    fl = 16'(f_l); vsw = 16'(v_s); vw = 16'(v_w); vv = 16'(v_v);
    hs_pol = ph; vs_pol = pv; de_pol = pd; de_pres = pres;
    fs0 = fs_cnt; rq0 = req_cnt;
    sync_on = 1'b1;
    repeat (cycles) @(negedge clk);
    #(CLK_PERIOD/4);
    sync_on = 1'b0;
    repeat (4) @(negedge clk);
    #(CLK_PERIOD/4);
    check_int("R8 frame_start count", fs_cnt - fs0, exp_fs);
    check_int("R4 R5 pix_req count", req_cnt - rq0, exp_req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state with mixed polarities
    repeat (3) @(negedge clk);
    tests++;
    if (hsync_o !== 1'b0 || vsync_o !== 1'b1 || de_o !== 1'b1 ||
        pix_req_o !== 1'b0 || frame_start_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: actual %b%b%b%b%b expected 01100",
               hsync_o, vsync_o, de_o, pix_req_o, frame_start_o);
    end
    #(CLK_PERIOD/4);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: gate low after reset keeps outputs inactive (scoreboard checks)
    // R7 active-high set, two frames
    run_cfg(20, 3, 6, 8, 10, 2, 3, 4, 1, 1, 1, 1, 400, 2, 64);
    // R7 active-low, de_present off (R6), windows reaching last count and line
    run_cfg(16, 1, 2, 14, 6, 1, 1, 5, 0, 0, 0, 0, 288, 3, 210);
    // R9: gate dropped mid-frame, then restart from (0,0)
    run_cfg(20, 3, 6, 8, 10, 2, 3, 4, 1, 0, 1, 1, 57, 1, 0);
    run_cfg(20, 3, 6, 8, 10, 2, 3, 4, 1, 0, 1, 1, 200, 1, 32);
    // R4: zero valid pixels, syncs covering whole line/frame
    run_cfg(8, 8, 0, 0, 4, 4, 0, 4, 0, 1, 0, 1, 32, 1, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule